// File: doc/BRIEF.md
# Direct-Mapped Cache Controller

This block is a small direct-mapped cache that sits between a processor port and a slower byte-wide backing memory. The processor presents a byte address with a read or a write strobe. The cache splits the address into three fields: a byte offset within the line, a line index and a tag. It keeps one valid bit, one tag and one line of data for each index. When the indexed line is valid and its tag matches, the access is a hit and completes at once. On a miss the processor is stalled, the whole line is brought in from memory, and the access then finishes as a hit would.

The line size and the number of lines are parameters; both must be powers of two. The address width is a parameter, and the default configuration uses a 5-bit address. A compile-time parameter chooses the write policy. With write-through, every processor write goes to memory at once, and the processor waits until memory accepts it. With write-back, a write stays in the cache and marks its line dirty, and a dirty line is copied back to memory only when a different tag needs its slot. Write misses allocate the line in both modes.

The memory port uses a request/acknowledge handshake, one byte per transaction, and the latency can vary. Each request is held until an acknowledge arrives. Read data from memory is taken in the cycle that carries the acknowledge.

Top module: `dmcache_top`

## Requirements
- R1: After reset every line is invalid, so the first access to any index reports a miss (`cpuHit` low when `cpuStall` falls).
- R2: The byte offset is the low log2(LINE_BYTES) address bits. The index is the next log2(NUM_LINES) bits, and the tag is the remaining upper bits. An access hits only when the indexed line is valid and holds the same tag; otherwise it misses and `cpuHit` is 0.
- R3: A read hit has `cpuStall` low in the same cycle the read strobe is first presented. `cpuRData` carries the stored byte, `cpuHit` is 1, and no memory request is made.
- R4: A read miss fetches every byte of the line with memory reads, in ascending offset order (offset 0 first). The data is returned, with `cpuStall` low and `cpuHit` 0, in the cycle after the last fill acknowledge.
- R5: A write miss first fills the whole line from memory, then writes the addressed byte. The other bytes of the line keep the values read from memory.
- R6: In write-through mode every write sends exactly one memory write (`memWe` = 1) of the byte to its own address, after any fill. `cpuStall` stays high until that write is acknowledged and falls in the acknowledge cycle. The cache copy is updated as well.
- R7: In write-back mode a write hit updates only the cache and completes in the cycle it is presented, with no memory request. The line then counts as dirty.
- R8: In write-back mode, a miss whose indexed line is valid and dirty first writes every byte of that line back to its old address, in ascending offset order, and only then starts the fill. A clean victim is not written back.
- R9: Filling a line leaves it clean. A line that was refilled and then only read is replaced later without any write-back.
- R10: While `memReq` is high and `memAck` is low, `memReq`, `memWe`, `memAddr` and `memWData` all hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuRd | input | 1 | Processor read strobe, held while stalled |
| cpuWr | input | 1 | Processor write strobe, held while stalled |
| cpuAddr | input | ADDR_W | Processor byte address |
| cpuWData | input | DATA_W | Processor write data |
| cpuRData | output | DATA_W | Read data, valid when `cpuStall` is low |
| cpuStall | output | 1 | High while the current access is not yet complete |
| cpuHit | output | 1 | With `cpuStall` low: 1 if the access hit on first lookup |
| memReq | output | 1 | Memory transaction request |
| memWe | output | 1 | 1 = memory write, 0 = memory read |
| memAddr | output | ADDR_W | Memory byte address |
| memWData | output | DATA_W | Memory write data |
| memRData | input | DATA_W | Memory read data, valid with `memAck` |
| memAck | input | 1 | One-cycle acknowledge that completes the request |

## Verification
The assertions rely on two things about the inputs. First, the processor keeps its strobe, address and write data steady from the first cycle of an access until the cycle in which `cpuStall` is low, and it never raises both strobes together. Second, the memory answers only an open request, with a single-cycle acknowledge. The bench drives each access at a falling edge and keeps it unchanged until it samples stall low. It then changes the inputs only at the next falling edge. Its memory model raises one acknowledge per request after a random wait and drops it one cycle later. Random addresses cover the full 5-bit space, so tag conflicts, dirty evictions and partial-line allocation all occur alongside the directed sequence.

// File: rtl/dmcache_pkg.sv
package dmcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_EVICT = 2'd1,
    ST_FILL  = 2'd2,
    ST_WTHRU = 2'd3
  } cacheState_e;

  // strobes from the control FSM into the storage datapath
  typedef struct packed {
    logic fillWr;    // store memRData at the fill byte slot
    logic commit;    // mark line valid, load tag, clear dirty
    logic cpuWrite;  // store processor byte
    logic markDirty; // set dirty bit of indexed line
    logic victimSel; // memory address/data come from the resident line
    logic lineSel;   // memory address is new line base plus byte counter
  } cacheStrobe_t;

endpackage

// File: rtl/dmcache_datapath.sv
module dmcache_datapath
  import dmcache_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int LINE_BYTES = 2,
  parameter int NUM_LINES  = 4,
  parameter int CNT_W      = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  input  logic [DATA_W-1:0] memRData,
  input  cacheStrobe_t      strobe,
  input  logic [CNT_W-1:0]  byteSel,
  output logic              lookupHit,
  output logic              victimDirty,
  output logic [DATA_W-1:0] cpuRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData
);

  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int SLOT_W = OFF_W + IDX_W;
  localparam int TAG_W  = ADDR_W - SLOT_W;
  localparam int SLOTS  = NUM_LINES * LINE_BYTES;

  logic [NUM_LINES-1:0] validQ;
  logic [NUM_LINES-1:0] dirtyQ;
  logic [TAG_W-1:0]     tagQ  [NUM_LINES];
  logic [DATA_W-1:0]    dataQ [SLOTS];

  logic [IDX_W-1:0]  idxF;
  logic [TAG_W-1:0]  tagF;
  logic [SLOT_W-1:0] cpuSlot;
  logic [SLOT_W-1:0] cntSlot;
  logic [ADDR_W-1:0] newLineAddr;
  logic [ADDR_W-1:0] oldLineAddr;

  assign cpuSlot = cpuAddr[SLOT_W-1:0];
  assign idxF    = cpuAddr[SLOT_W-1 -: IDX_W];
  assign tagF    = cpuAddr[ADDR_W-1 -: TAG_W];

  generate
    if (OFF_W == 0) begin : g_byteLine
      assign cntSlot     = cpuSlot;
      assign newLineAddr = cpuAddr;
      assign oldLineAddr = {tagQ[idxF], idxF};
    end else begin : g_multiLine
      assign cntSlot     = {idxF, byteSel[OFF_W-1:0]};
      assign newLineAddr = {cpuAddr[ADDR_W-1:OFF_W], byteSel[OFF_W-1:0]};
      assign oldLineAddr = {tagQ[idxF], idxF, byteSel[OFF_W-1:0]};
    end
  endgenerate

  assign lookupHit   = validQ[idxF] && (tagQ[idxF] == tagF);
  assign victimDirty = validQ[idxF] && dirtyQ[idxF];
  assign cpuRData    = dataQ[cpuSlot];

  always_comb begin
    if (strobe.victimSel)    memAddr = oldLineAddr;
    else if (strobe.lineSel) memAddr = newLineAddr;
    else                     memAddr = cpuAddr;
    memWData = strobe.victimSel ? dataQ[cntSlot] : cpuWData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      dirtyQ <= '0;
    end else begin
      if (strobe.commit) begin
        validQ[idxF] <= 1'b1;
        dirtyQ[idxF] <= 1'b0;
      end else if (strobe.markDirty) begin
        dirtyQ[idxF] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.commit)   tagQ[idxF]     <= tagF;
    if (strobe.fillWr)   dataQ[cntSlot] <= memRData;
    if (strobe.cpuWrite) dataQ[cpuSlot] <= cpuWData;
  end

  // R1: the cycle after reset releases, no line is valid
  a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (validQ == '0));

  // R2: a freshly committed line hits on the held address
  a_r2_commit_hits: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |=> lookupHit);

  // R7: only a resident line can turn dirty
  a_r7_dirty_only_hit: assert property (@(posedge clk) disable iff (!rstN)
    strobe.markDirty |-> lookupHit);

endmodule

// File: rtl/dmcache_control.sv
module dmcache_control
  import dmcache_pkg::*;
#(
  parameter int LINE_BYTES = 2,
  parameter bit WRITE_BACK = 1'b1,
  parameter int CNT_W      = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuRd,
  input  logic             cpuWr,
  input  logic             lookupHit,
  input  logic             victimDirty,
  input  logic             memAck,
  output cacheStrobe_t     strobe,
  output logic [CNT_W-1:0] byteSel,
  output logic             cpuStall,
  output logic             cpuHit,
  output logic             memReq,
  output logic             memWe
);

  cacheState_e      stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic             missQ, missD;
  logic             req, done, lastByte;

  assign req      = cpuRd | cpuWr;
  assign lastByte = (cntQ == CNT_W'(LINE_BYTES - 1));
  assign byteSel  = cntQ;
  assign cpuStall = req && !done;
  assign cpuHit   = !missQ;

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    missD  = missQ;
    strobe = '0;
    done   = 1'b0;
    memReq = 1'b0;
    memWe  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (req) begin
          if (lookupHit) begin
            if (!cpuWr) begin
              done = 1'b1;
            end else if (WRITE_BACK) begin
              strobe.cpuWrite  = 1'b1;
              strobe.markDirty = 1'b1;
              done             = 1'b1;
            end else begin
              stateD = ST_WTHRU;
            end
          end else begin
            missD  = 1'b1;
            cntD   = '0;
            stateD = (WRITE_BACK && victimDirty) ? ST_EVICT : ST_FILL;
          end
        end
      end
      ST_EVICT: begin
        memReq           = 1'b1;
        memWe            = 1'b1;
        strobe.victimSel = 1'b1;
        if (memAck) begin
          if (lastByte) begin
            cntD   = '0;
            stateD = ST_FILL;
          end else begin
            cntD = cntQ + 1'b1;
          end
        end
      end
      ST_FILL: begin
        memReq         = 1'b1;
        strobe.lineSel = 1'b1;
        if (memAck) begin
          strobe.fillWr = 1'b1;
          if (lastByte) begin
            strobe.commit = 1'b1;
            cntD          = '0;
            stateD        = ST_IDLE;
          end else begin
            cntD = cntQ + 1'b1;
          end
        end
      end
      ST_WTHRU: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) begin
          strobe.cpuWrite = 1'b1;
          done            = 1'b1;
          stateD          = ST_IDLE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
    if (done) missD = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      missQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      missQ  <= missD;
    end
  end

  // R4: the processor waits while a memory transaction is open
  a_r4_stall_while_mem: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |-> cpuStall);

  // R8: last write-back byte hands over to a fill starting at offset 0
  a_r8_evict_then_fill: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_EVICT && memAck && lastByte) |=> (stateQ == ST_FILL && cntQ == '0));

  // R7: in write-back mode a completed write hit leaves memory idle
  a_r7_wb_hit_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (WRITE_BACK && stateQ == ST_IDLE && cpuWr && lookupHit) |=> !memReq);

endmodule

// File: rtl/dmcache_top.sv
module dmcache_top
  import dmcache_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 8,
  parameter int LINE_BYTES = 2,
  parameter int NUM_LINES  = 4,
  parameter bit WRITE_BACK = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuRd,
  input  logic              cpuWr,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0] cpuWData,
  output logic [DATA_W-1:0] cpuRData,
  output logic              cpuStall,
  output logic              cpuHit,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  input  logic              memAck
);

  localparam int OFF_W = $clog2(LINE_BYTES);
  localparam int CNT_W = (OFF_W == 0) ? 1 : OFF_W;

  cacheStrobe_t     strobe;
  logic [CNT_W-1:0] byteSel;
  logic             lookupHit, victimDirty;

  dmcache_control #(
    .LINE_BYTES(LINE_BYTES), .WRITE_BACK(WRITE_BACK), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr),
    .lookupHit(lookupHit), .victimDirty(victimDirty), .memAck(memAck),
    .strobe(strobe), .byteSel(byteSel), .cpuStall(cpuStall), .cpuHit(cpuHit),
    .memReq(memReq), .memWe(memWe)
  );

  dmcache_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuWData(cpuWData),
    .memRData(memRData), .strobe(strobe), .byteSel(byteSel),
    .lookupHit(lookupHit), .victimDirty(victimDirty), .cpuRData(cpuRData),
    .memAddr(memAddr), .memWData(memWData)
  );

  // R10: an open memory request holds steady until acknowledged
  a_r10_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWData)));

endmodule

// File: tb/dmcache_tb_core.sv
module dmcache_tb_core #(
  parameter int LINE_BYTES = 2,
  parameter int NUM_LINES  = 4,
  parameter bit WRITE_BACK = 1'b1,
  parameter int SEED       = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  int unsigned cyc,
  output int          nChk,
  output int          nErr,
  output logic        fin
);

  logic       cpuRd, cpuWr, cpuStall, cpuHit, memReq, memWe, memAck;
  logic [4:0] cpuAddr, memAddr;
  logic [7:0] cpuWData, cpuRData, memWData, memRData;

  dmcache_top #(
    .ADDR_W(5), .DATA_W(8), .LINE_BYTES(LINE_BYTES),
    .NUM_LINES(NUM_LINES), .WRITE_BACK(WRITE_BACK)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cpuRd(cpuRd), .cpuWr(cpuWr), .cpuAddr(cpuAddr),
    .cpuWData(cpuWData), .cpuRData(cpuRData), .cpuStall(cpuStall), .cpuHit(cpuHit),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWData(memWData),
    .memRData(memRData), .memAck(memAck)
  );

  logic [7:0]  memArr  [32];
  logic [7:0]  logical [32];
  bit          mVal    [NUM_LINES];
  int          mTag    [NUM_LINES];
  bit          mDirty  [NUM_LINES];
  int          opN;
  bit          opWe    [16];
  int          opAddr  [16];
  int unsigned lastAckCyc;
  bit          pending;
  int          lat;
  logic [4:0]  hAddr;
  logic [7:0]  hWData;
  logic        hWe;

  function automatic logic [7:0] initVal(input int a);
    return 8'(a * 37 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s (WB=%0d LB=%0d) actual %0d expected %0d",
               req, WRITE_BACK, LINE_BYTES, act, exp);
    end
  endtask

  // memory model: random wait, one-cycle acknowledge
  always @(negedge clk) begin
    if (!rstN) begin
      memAck  = 1'b0;
      pending = 1'b0;
    end else if (memAck) begin
      memAck  = 1'b0;
      pending = 1'b0;
    end else if (memReq) begin
      if (!pending) begin
        pending = 1'b1;
        lat     = $urandom_range(3, 0);
        hAddr   = memAddr;
        hWe     = memWe;
        hWData  = memWData;
      end
      if (lat == 0) begin
        // R10: request fields unchanged while waiting
        chk(hAddr == memAddr && hWe == memWe && (!memWe || hWData == memWData),
            "R10", int'(memAddr), int'(hAddr));
        if (memWe) memArr[memAddr] = memWData;
        else       memRData = memArr[memAddr];
        if (opN < 16) begin
          opWe[opN]   = memWe;
          opAddr[opN] = int'(memAddr);
        end
        opN++;
        lastAckCyc = cyc;
        memAck     = 1'b1;
      end else begin
        lat--;
      end
    end
  end

  task automatic access(input bit wr, input int a, input logic [7:0] d, input string firstTag,
                        output logic [7:0] rd);
    int idx, tag, base, en, expData;
    bit expHit, evict;
    bit eWe [16];
    int eAddr [16];
    int unsigned startCyc, doneCyc, expDone;
    string opTag;
    bit memOk;
    int badAddr;
    idx  = (a / LINE_BYTES) % NUM_LINES;
    tag  = a / (LINE_BYTES * NUM_LINES);
    base = a - (a % LINE_BYTES);
    expHit  = mVal[idx] && mTag[idx] == tag;
    expData = int'(logical[a]);
    evict   = !expHit && WRITE_BACK && mVal[idx] && mDirty[idx];
    en = 0;
    if (!expHit) begin
      if (evict)
        for (int k = 0; k < LINE_BYTES; k++) begin
          eWe[en] = 1'b1; eAddr[en] = (mTag[idx] * NUM_LINES + idx) * LINE_BYTES + k; en++;
        end
      for (int k = 0; k < LINE_BYTES; k++) begin
        eWe[en] = 1'b0; eAddr[en] = base + k; en++;
      end
    end
    if (wr && !WRITE_BACK) begin
      eWe[en] = 1'b1; eAddr[en] = a; en++;
    end
    if (!wr && !WRITE_BACK || !wr) opTag = expHit ? "R3" : "R4";
    if (wr) opTag = !WRITE_BACK ? "R6" : (expHit ? "R7" : "R5");
    if (evict) opTag = "R8";

    opN      = 0;
    startCyc = cyc;
    cpuAddr  = 5'(a);
    cpuWData = d;
    cpuRd    = !wr;
    cpuWr    = wr;
    #1;
    while (cpuStall) begin
      @(negedge clk);
      #1;
    end
    doneCyc = cyc;
    rd      = cpuRData;

    chk(cpuHit == expHit, (firstTag != "") ? firstTag : "R2", int'(cpuHit), int'(expHit));
    if (!wr) chk(int'(cpuRData) == expData, expHit ? "R3" : "R4", int'(cpuRData), expData);
    chk(opN == en, opTag, opN, en);
    for (int k = 0; k < en && k < opN; k++)
      chk(opWe[k] == eWe[k] && opAddr[k] == eAddr[k], opTag, opAddr[k], eAddr[k]);
    if (expHit && !(wr && !WRITE_BACK)) expDone = startCyc;
    else if (wr && !WRITE_BACK)        expDone = lastAckCyc;
    else                               expDone = lastAckCyc + 1;
    chk(doneCyc == expDone, opTag, int'(doneCyc - startCyc), int'(expDone - startCyc));

    if (!expHit) begin
      mVal[idx] = 1'b1; mTag[idx] = tag; mDirty[idx] = 1'b0;
    end
    if (wr) begin
      logical[a] = d;
      if (WRITE_BACK) mDirty[idx] = 1'b1;
    end
    // memory holds the logical value except under a dirty resident line
    memOk = 1'b1;
    badAddr = 0;
    for (int b = 0; b < 32; b++) begin
      int bi, bt;
      bi = (b / LINE_BYTES) % NUM_LINES;
      bt = b / (LINE_BYTES * NUM_LINES);
      if (!(WRITE_BACK && mVal[bi] && mDirty[bi] && mTag[bi] == bt) && memArr[b] != logical[b]) begin
        memOk = 1'b0; badAddr = b;
      end
    end
    chk(memOk, WRITE_BACK ? "R8" : "R6", int'(memArr[badAddr]), int'(logical[badAddr]));

    @(negedge clk);
    cpuRd = 1'b0;
    cpuWr = 1'b0;
  endtask

  initial begin
    logic [7:0] rd;
    int wrCount;
    nChk = 0; nErr = 0; fin = 1'b0; opN = 0; lat = 0; pending = 1'b0;
    memAck = 1'b0; memRData = '0; lastAckCyc = 0;
    cpuRd = 1'b0; cpuWr = 1'b0; cpuAddr = '0; cpuWData = '0;
    for (int i = 0; i < 32; i++) begin
      memArr[i] = initVal(i); logical[i] = initVal(i);
    end
    for (int i = 0; i < NUM_LINES; i++) begin
      mVal[i] = 1'b0; mTag[i] = 0; mDirty[i] = 1'b0;
    end
    void'($urandom(SEED));
    wait (rstN);
    @(negedge clk);

    // directed walk: reads, a write miss, a neighbour read, a conflicting tag
    access(1'b0, 0, 8'h00, "R1", rd);
    access(1'b0, 1, 8'h00, "", rd);
    access(1'b1, 10, 8'h5A, "R1", rd);
    access(1'b0, 11, 8'h00, "", rd);
    chk(rd == initVal(11), "R5", int'(rd), int'(initVal(11)));
    access(1'b0, 26, 8'h00, "", rd);
    access(1'b0, 10, 8'h00, "", rd);
    chk(rd == 8'h5A, "R5", int'(rd), 8'h5A);

    // dirty line replaced, then the refilled clean line replaced
    access(1'b1, 0, 8'hA5, "", rd);
    access(1'b0, 8, 8'h00, "", rd);
    access(1'b0, 0, 8'h00, "", rd);
    wrCount = 0;
    for (int k = 0; k < opN && k < 16; k++) if (opWe[k]) wrCount++;
    chk(wrCount == 0, "R9", wrCount, 0);
    chk(rd == 8'hA5, "R8", int'(rd), 8'hA5);
    // repeated write hit on one line
    access(1'b1, 1, 8'h3C, "", rd);
    access(1'b1, 1, 8'hC3, "", rd);
    access(1'b0, 1, 8'h00, "", rd);
    chk(rd == 8'hC3, "R7", int'(rd), 8'hC3);

    for (int n = 0; n < 300; n++) begin
      bit w;
      w = ($urandom_range(9, 0) < 4);
      access(w, int'($urandom_range(31, 0)), 8'($urandom()), "", rd);
    end
    fin = 1'b1;
  end

endmodule

// File: tb/dmcache_top_tb_top.sv
module dmcache_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  int unsigned cyc = 0;
  int          chkA, errA, chkB, errB;
  logic        finA, finB;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // write-back, 4 lines of 2 bytes
  dmcache_tb_core #(.LINE_BYTES(2), .NUM_LINES(4), .WRITE_BACK(1'b1), .SEED(11)) wb_core (
    .clk(clk), .rstN(rstN), .cyc(cyc), .nChk(chkA), .nErr(errA), .fin(finA));

  // write-through, 8 lines of 1 byte
  dmcache_tb_core #(.LINE_BYTES(1), .NUM_LINES(8), .WRITE_BACK(1'b0), .SEED(23)) wt_core (
    .clk(clk), .rstN(rstN), .cyc(cyc), .nChk(chkB), .nErr(errB), .fin(finB));

  initial begin
    int totalErr;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    wait ((finA && finB) || cyc > 150000);
    totalErr = errA + errB;
    if (!(finA && finB)) begin
      totalErr++;
      $display("FAIL watchdog: run did not finish, actual %0d expected finished", cyc);
    end
    $display("CHECKS %0d ERRORS %0d", chkA + chkB + 1, totalErr);
    $finish;
  end

endmodule